// File: doc/BRIEF.md
# Interrupt Acceptance and Vectoring Unit

This unit decides when an 8-bit CPU core with a 16-bit address space leaves its instruction stream to serve an interrupt, and where it goes. It owns the two interrupt-enable flags (the live enable and its saved copy), a 2-bit maskable-mode register and an 8-bit vector base register. Two request lines arrive from the system. One is a level-sensitive maskable line that the enable state can block. The other is an edge-sensitive nonmaskable line that is always honoured. Both are looked at only when the core marks an instruction boundary.

When a request is taken, the unit pulses a push request carrying the PC the core supplied, so that the core stacks its return address. In the same cycle it either presents a jump target or tells the core to fetch and execute the opcode byte that the device drives onto the data bus. The core reports the enable, disable, mode-set, vector-base load and the two return kinds through single-cycle strobes. The unit updates its flags from them, and it pulses an acknowledge toward peripherals on the maskable-return strobe.

The block has no notion of instructions, stack memory or bus cycles. The core sequences all of those, using the unit's one-cycle pulses.

Top module: `irq_accept_unit`

## Requirements
- R1: After synchronous reset, the live enable, the saved enable, the mode register, the vector base, the nonmaskable pending flag and the in-service flag are all 0, and every pulse output is low.
- R2: An enable strobe sets both enable flags to 1 and a disable strobe clears both. Disable wins when both strobes come in the same cycle.
- R3: A mode-set strobe stores mode_val_i when it is 0 (execute bus opcode), 1 (fixed restart) or 2 (vectored). The value 3 leaves the mode unchanged, so mode_o never reads 3.
- R4: Requests are sampled only on a clock edge where boundary_i is 1. A maskable request is taken only while the live enable is 1 and no interrupt is in service.
- R5: A 0-to-1 transition on nmi_i sets a pending flag, which the next boundary takes whatever the enable state. The flag is cleared on acceptance, and a line held high does not retrigger. A pending nonmaskable request is taken in preference to a maskable one at the same boundary.
- R6: On nonmaskable acceptance the saved enable takes the old live enable, the live enable becomes 0, and the target is 0x0066.
- R7: On maskable acceptance both enable flags become 0.
- R8: On maskable acceptance, mode 1 gives target 0x0038 with jump_o high. Mode 2 gives target {vector base, dev_byte_i} with jump_o high. Mode 0 pulses opfetch_o with jump_o low.
- R9: Every acceptance pulses push_req_o for one cycle with push_pc_o equal to pc_i at the sampling edge. The pulse appears in the cycle after that edge, together with jump_o or opfetch_o (exactly one of the two).
- R10: A nonmaskable-return strobe copies the saved enable into the live enable and ends the in-service state.
- R11: A maskable-return strobe pulses reti_ack_o in the next cycle and ends the in-service state.
- R12: In one cycle the flag updates take effect with this precedence: acceptance, then nonmaskable return, then disable, then enable. A strobe that lands in the same cycle as an acceptance leaves no trace on the flags. The in-service flag is set by acceptance in preference to being cleared by a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Core is at an instruction boundary |
| int_i | input | 1 | Maskable request, level |
| nmi_i | input | 1 | Nonmaskable request, edge |
| dev_byte_i | input | 8 | Device byte on the data bus |
| pc_i | input | 16 | Current PC from the core |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| mode_wr_i | input | 1 | Mode-set strobe |
| mode_val_i | input | 2 | Mode value for the mode-set strobe |
| vbase_wr_i | input | 1 | Vector base load strobe |
| vbase_val_i | input | 8 | Vector base value |
| retn_i | input | 1 | Nonmaskable-return strobe |
| reti_i | input | 1 | Maskable-return strobe |
| push_req_o | output | 1 | Push the return PC (one cycle) |
| push_pc_o | output | 16 | PC to push |
| jump_o | output | 1 | Branch to target_o (one cycle) |
| target_o | output | 16 | Handler address |
| opfetch_o | output | 1 | Execute the opcode on the data bus (one cycle) |
| reti_ack_o | output | 1 | Peripheral acknowledge (one cycle) |
| iff1_o | output | 1 | Live enable flag |
| iff2_o | output | 1 | Saved enable flag |
| mode_o | output | 2 | Current maskable mode |

## Verification
The hardest state to reach is a nonmaskable entry taken while a maskable handler has already re-enabled interrupts. In that state the saved enable must carry a 1 through the nonmaskable handler, and the return must restore it without a second maskable entry slipping in while the first is still in service. The stimulus gets there with a directed chain: accept a maskable request, strobe enable inside the handler, raise nmi_i, then strobe the nonmaskable return. A long pseudo-random phase follows, with strobes colliding with acceptances. A behavioural model checks every cycle of it.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        IM_BUS     = 2'd0,
        IM_RESTART = 2'd1,
        IM_VECTOR  = 2'd2
    } imode_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_MASK = 2'd2
    } src_e;

    typedef struct packed {
        logic iff1;
        logic iff2;
    } enables_t;

    // only three of the four codes name a mode
    function automatic logic mode_code_ok(input logic [1:0] v);
        return v != 2'd3;
    endfunction

    // new enable pair for one cycle, precedence: accept, retn, di, ei
    function automatic enables_t next_enables(
        input enables_t cur,
        input src_e     src,
        input logic     retn,
        input logic     di,
        input logic     ei
    );
        enables_t n;
        n = cur;
        if (src == SRC_NMI) begin
            n.iff2 = cur.iff1;
            n.iff1 = 1'b0;
        end else if (src == SRC_MASK) begin
            n.iff1 = 1'b0;
            n.iff2 = 1'b0;
        end else if (retn) begin
            n.iff1 = cur.iff2;
        end else if (di) begin
            n.iff1 = 1'b0;
            n.iff2 = 1'b0;
        end else if (ei) begin
            n.iff1 = 1'b1;
            n.iff2 = 1'b1;
        end
        return n;
    endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_i,
    input  logic taken_i,
    output logic pending_o
);
    logic nmi_q;
    logic rise;

    assign rise = nmi_i & ~nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q     <= 1'b0;
            pending_o <= 1'b0;
        end else begin
            nmi_q <= nmi_i;
            if (rise)
                pending_o <= 1'b1;
            else if (taken_i)
                pending_o <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic boundary_i,
    input  logic nmi_pending_i,
    input  logic int_i,
    input  logic iff1_i,
    input  logic busy_i,
    output src_e src_o
);
    always_comb begin
        src_o = SRC_NONE;
        if (boundary_i) begin
            if (nmi_pending_i)
                src_o = SRC_NMI;
            else if (int_i && iff1_i && !busy_i)
                src_o = SRC_MASK;
        end
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
    import irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  src_e              src_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              retn_i,
    input  logic              reti_i,
    input  logic              mode_wr_i,
    input  logic [1:0]        mode_val_i,
    input  logic              vbase_wr_i,
    input  logic [DATA_W-1:0] vbase_val_i,
    output enables_t          en_o,
    output imode_e            mode_o,
    output logic [DATA_W-1:0] vbase_o,
    output logic              busy_o
);
    logic accepted;
    assign accepted = (src_i != SRC_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o   <= '0;
            mode_o <= IM_BUS;
            vbase_o <= '0;
            busy_o <= 1'b0;
        end else begin
            en_o <= next_enables(en_o, src_i, retn_i, di_i, ei_i);
            if (mode_wr_i && mode_code_ok(mode_val_i))
                mode_o <= imode_e'(mode_val_i);
            if (vbase_wr_i)
                vbase_o <= vbase_val_i;
            if (accepted)
                busy_o <= 1'b1;
            else if (reti_i || retn_i)
                busy_o <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
    import irq_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] NMI_VEC  = 16'h0066,
    parameter logic [ADDR_W-1:0] RST_VEC  = 16'h0038
) (
    input  logic              clk,
    input  logic              rst,
    input  src_e              src_i,
    input  imode_e            mode_i,
    input  logic [DATA_W-1:0] vbase_i,
    input  logic [DATA_W-1:0] dev_byte_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              reti_i,
    output logic              push_req_o,
    output logic [ADDR_W-1:0] push_pc_o,
    output logic              jump_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              opfetch_o,
    output logic              reti_ack_o
);
    localparam int VEC_W = 2 * DATA_W;

    logic [ADDR_W-1:0] vec_addr;
    logic [ADDR_W-1:0] tgt_d;
    logic              jump_d;
    logic              fetch_d;

    always_comb begin
        vec_addr               = '0;
        vec_addr[DATA_W-1:0]   = dev_byte_i;
        vec_addr[VEC_W-1:DATA_W] = vbase_i;
    end

    always_comb begin
        tgt_d   = '0;
        jump_d  = 1'b0;
        fetch_d = 1'b0;
        unique case (src_i)
            SRC_NMI: begin
                tgt_d  = NMI_VEC;
                jump_d = 1'b1;
            end
            SRC_MASK: begin
                unique case (mode_i)
                    IM_RESTART: begin tgt_d = RST_VEC;  jump_d = 1'b1; end
                    IM_VECTOR:  begin tgt_d = vec_addr; jump_d = 1'b1; end
                    default:    fetch_d = 1'b1;
                endcase
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            push_req_o <= 1'b0;
            push_pc_o  <= '0;
            jump_o     <= 1'b0;
            target_o   <= '0;
            opfetch_o  <= 1'b0;
            reti_ack_o <= 1'b0;
        end else begin
            push_req_o <= (src_i != SRC_NONE);
            jump_o     <= jump_d;
            opfetch_o  <= fetch_d;
            reti_ack_o <= reti_i;
            if (src_i != SRC_NONE)
                push_pc_o <= pc_i;
            if (jump_d)
                target_o <= tgt_d;
        end
    end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
    parameter logic [ADDR_W-1:0] RST_VEC = 16'h0038
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_i,
    input  logic              int_i,
    input  logic              nmi_i,
    input  logic [DATA_W-1:0] dev_byte_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              ei_i,
    input  logic              di_i,
    input  logic              mode_wr_i,
    input  logic [1:0]        mode_val_i,
    input  logic              vbase_wr_i,
    input  logic [DATA_W-1:0] vbase_val_i,
    input  logic              retn_i,
    input  logic              reti_i,
    output logic              push_req_o,
    output logic [ADDR_W-1:0] push_pc_o,
    output logic              jump_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              opfetch_o,
    output logic              reti_ack_o,
    output logic              iff1_o,
    output logic              iff2_o,
    output logic [1:0]        mode_o
);
    src_e              src;
    logic              nmi_pending;
    enables_t          en;
    imode_e            mode;
    logic [DATA_W-1:0] vbase;
    logic              busy;

    irq_nmi_latch u_nmi (
        .clk       (clk),
        .rst       (rst),
        .nmi_i     (nmi_i),
        .taken_i   (src == SRC_NMI),
        .pending_o (nmi_pending)
    );

    irq_arbiter u_arb (
        .boundary_i    (boundary_i),
        .nmi_pending_i (nmi_pending),
        .int_i         (int_i),
        .iff1_i        (en.iff1),
        .busy_i        (busy),
        .src_o         (src)
    );

    irq_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .src_i       (src),
        .ei_i        (ei_i),
        .di_i        (di_i),
        .retn_i      (retn_i),
        .reti_i      (reti_i),
        .mode_wr_i   (mode_wr_i),
        .mode_val_i  (mode_val_i),
        .vbase_wr_i  (vbase_wr_i),
        .vbase_val_i (vbase_val_i),
        .en_o        (en),
        .mode_o      (mode),
        .vbase_o     (vbase),
        .busy_o      (busy)
    );

    irq_vector_gen #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NMI_VEC (NMI_VEC),
        .RST_VEC (RST_VEC)
    ) u_vec (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src),
        .mode_i     (mode),
        .vbase_i    (vbase),
        .dev_byte_i (dev_byte_i),
        .pc_i       (pc_i),
        .reti_i     (reti_i),
        .push_req_o (push_req_o),
        .push_pc_o  (push_pc_o),
        .jump_o     (jump_o),
        .target_o   (target_o),
        .opfetch_o  (opfetch_o),
        .reti_ack_o (reti_ack_o)
    );

    assign iff1_o = en.iff1;
    assign iff2_o = en.iff2;
    assign mode_o = mode;
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk (
    input logic       clk,
    input logic       rst,
    input logic       boundary_i,
    input logic       reti_i,
    input logic       push_req_o,
    input logic       jump_o,
    input logic       opfetch_o,
    input logic       reti_ack_o,
    input logic       iff1_o,
    input logic [1:0] mode_o
);
    // R9
    push_kind_chk: assert property (@(posedge clk) disable iff (rst)
        push_req_o |-> (jump_o ^ opfetch_o));

    // R9
    branch_needs_push_chk: assert property (@(posedge clk) disable iff (rst)
        (jump_o || opfetch_o) |-> push_req_o);

    // R4
    boundary_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(push_req_o) |-> $past(boundary_i));

    // R6
    entry_masks_chk: assert property (@(posedge clk) disable iff (rst)
        push_req_o |-> !iff1_o);

    // R11
    ack_follows_chk: assert property (@(posedge clk) disable iff (rst)
        reti_ack_o |-> $past(reti_i));

    // R11
    ack_given_chk: assert property (@(posedge clk) disable iff (rst)
        $past(reti_i && !rst) |-> reti_ack_o);

    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'd3);
endmodule

bind irq_accept_unit irq_accept_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .boundary_i (boundary_i),
    .reti_i     (reti_i),
    .push_req_o (push_req_o),
    .jump_o     (jump_o),
    .opfetch_o  (opfetch_o),
    .reti_ack_o (reti_ack_o),
    .iff1_o     (iff1_o),
    .mode_o     (mode_o)
);

// File: tb/tb_irq_accept_unit.sv
`timescale 1ns/1ps
module tb_irq_accept_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary_i = 0, int_i = 0, nmi_i = 0;
    logic [7:0]  dev_byte_i = 0, vbase_val_i = 0;
    logic [15:0] pc_i = 0;
    logic        ei_i = 0, di_i = 0, mode_wr_i = 0, vbase_wr_i = 0, retn_i = 0, reti_i = 0;
    logic [1:0]  mode_val_i = 0;
    logic        push_req_o, jump_o, opfetch_o, reti_ack_o, iff1_o, iff2_o;
    logic [15:0] push_pc_o, target_o;
    logic [1:0]  mode_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    irq_accept_unit dut (.*);

    // behavioural reference state
    int m_iff1, m_iff2, m_mode, m_vb, m_busy, m_pend, m_prev;
    int m_push, m_pc, m_jump, m_tgt, m_fetch, m_ack;

    always @(posedge clk) begin
        int an, ai, edge_now, old1, old2;
        cycles++;
        if (rst) begin
            m_iff1 = 0; m_iff2 = 0; m_mode = 0; m_vb = 0; m_busy = 0; m_pend = 0; m_prev = 0;
            m_push = 0; m_pc = 0; m_jump = 0; m_tgt = 0; m_fetch = 0; m_ack = 0;
        end else begin
            edge_now = (nmi_i && !m_prev) ? 1 : 0;
            an = (boundary_i && m_pend) ? 1 : 0;
            ai = (boundary_i && !an && int_i && m_iff1 && !m_busy) ? 1 : 0;
            old1 = m_iff1; old2 = m_iff2;
            m_push = an | ai;
            if (m_push) m_pc = pc_i;
            m_jump  = (an || (ai && m_mode != 0)) ? 1 : 0;
            m_fetch = (ai && m_mode == 0) ? 1 : 0;
            if (an) m_tgt = 'h66;
            else if (ai && m_mode == 1) m_tgt = 'h38;
            else if (ai && m_mode == 2) m_tgt = m_vb * 256 + dev_byte_i;
            m_ack = reti_i;
            if (an) begin m_iff2 = old1; m_iff1 = 0; end
            else if (ai) begin m_iff1 = 0; m_iff2 = 0; end
            else if (retn_i) m_iff1 = old2;
            else if (di_i) begin m_iff1 = 0; m_iff2 = 0; end
            else if (ei_i) begin m_iff1 = 1; m_iff2 = 1; end
            if (mode_wr_i && mode_val_i != 3) m_mode = mode_val_i;
            if (vbase_wr_i) m_vb = vbase_val_i;
            if (m_push) m_busy = 1;
            else if (reti_i || retn_i) m_busy = 0;
            if (edge_now) m_pend = 1;
            else if (an) m_pend = 0;
            m_prev = nmi_i;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 iff1", iff1_o, m_iff1);
            chk("R6 iff2", iff2_o, m_iff2);
            chk("R3 mode", mode_o, m_mode);
            chk("R9 push", push_req_o, m_push);
            if (m_push) chk("R9 pc", push_pc_o, m_pc);
            chk("R8 jump", jump_o, m_jump);
            if (m_jump) chk("R8 target", target_o, m_tgt);
            chk("R8 opfetch", opfetch_o, m_fetch);
            chk("R11 ack", reti_ack_o, m_ack);
        end
    end

    task automatic clr;
        boundary_i = 0; ei_i = 0; di_i = 0; mode_wr_i = 0; vbase_wr_i = 0;
        retn_i = 0; reti_i = 0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int unsigned r;
        step(3);
        rst = 0;
        step(1);
        // R1
        chk("R1 iff1", iff1_o, 0); chk("R1 iff2", iff2_o, 0); chk("R1 mode", mode_o, 0);
        chk("R1 push", push_req_o, 0); chk("R1 ack", reti_ack_o, 0);

        // R2
        ei_i = 1; step(1); clr;
        chk("R2 ei", {iff1_o, iff2_o}, 3);
        ei_i = 1; di_i = 1; step(1); clr;
        chk("R2 di wins", {iff1_o, iff2_o}, 0);

        // R3
        mode_wr_i = 1; mode_val_i = 2; step(1); clr;
        chk("R3 mode2", mode_o, 2);
        mode_wr_i = 1; mode_val_i = 3; step(1); clr;
        chk("R3 code3 ignored", mode_o, 2);

        // R4: no boundary, then enables off
        ei_i = 1; step(1); clr;
        int_i = 1; step(2);
        chk("R4 no boundary", push_req_o, 0);
        di_i = 1; step(1); clr;
        boundary_i = 1; step(1); clr;
        chk("R4 masked", push_req_o, 0);

        // R7 R8 R9: restart mode
        mode_wr_i = 1; mode_val_i = 1; ei_i = 1; step(1); clr;
        pc_i = 16'hBEEF; boundary_i = 1; step(1); clr;
        chk("R8 restart target", target_o, 16'h0038);
        chk("R9 pc pushed", push_pc_o, 16'hBEEF);
        chk("R7 iffs cleared", {iff1_o, iff2_o}, 0);
        step(1);
        chk("R9 one cycle", push_req_o, 0);

        // R4 in service, R11 ack ends service
        ei_i = 1; step(1); clr;
        boundary_i = 1; step(1); clr;
        chk("R4 in service blocks", push_req_o, 0);
        reti_i = 1; step(1); clr;
        chk("R11 ack pulse", reti_ack_o, 1);
        boundary_i = 1; step(1); clr;
        chk("R11 service ended", push_req_o, 1);
        int_i = 0;

        // R8 vectored
        vbase_wr_i = 1; vbase_val_i = 8'h12; mode_wr_i = 1; mode_val_i = 2; ei_i = 1; reti_i = 1;
        step(1); clr;
        int_i = 1; dev_byte_i = 8'h34; boundary_i = 1; step(1); clr;
        chk("R8 vector target", target_o, 16'h1234);
        int_i = 0;

        // R8 bus opcode mode
        mode_wr_i = 1; mode_val_i = 0; ei_i = 1; reti_i = 1; step(1); clr;
        int_i = 1; boundary_i = 1; step(1); clr;
        chk("R8 opfetch", {opfetch_o, jump_o}, 2);
        int_i = 0;

        // nested: handler re-enables, nmi arrives, R6 and R10
        ei_i = 1; step(1); clr;
        nmi_i = 1; step(1);
        chk("R5 pending only", push_req_o, 0);
        boundary_i = 1; step(1); clr;
        chk("R6 nmi target", target_o, 16'h0066);
        chk("R6 iff pair", {iff1_o, iff2_o}, 1);
        boundary_i = 1; step(1); clr;
        chk("R5 held no retrigger", push_req_o, 0);
        retn_i = 1; step(1); clr;
        chk("R10 restore", iff1_o, 1);
        nmi_i = 0;

        // R5 priority and R12 precedence
        reti_i = 1; step(1); clr;
        nmi_i = 1; int_i = 1; mode_wr_i = 1; mode_val_i = 1; step(1); clr;
        boundary_i = 1; ei_i = 1; step(1); clr;
        chk("R5 nmi first", target_o, 16'h0066);
        chk("R12 ei lost", iff1_o, 0);
        nmi_i = 0; int_i = 0;

        // pseudo-random collisions
        for (int i = 0; i < 4000; i++) begin
            r = $urandom;
            boundary_i = r[0] | r[1];
            int_i      = r[2];
            nmi_i      = (r[7:3] == 0) ? ~nmi_i : nmi_i;
            ei_i       = r[8] & r[9];
            di_i       = r[10] & r[11] & r[12];
            retn_i     = r[13] & r[14] & r[15];
            reti_i     = r[16] & r[17];
            mode_wr_i  = r[18] & r[19];
            mode_val_i = r[21:20];
            vbase_wr_i = r[22] & r[23];
            vbase_val_i = r[31:24];
            dev_byte_i = r[30:23];
            pc_i       = r[25:10];
            step(1);
        end
        clr;
        step(2);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected<190000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule